// File: doc/BRIEF.md
# SD Host Status and Interrupt Unit

This unit holds the event and card state of an SD/MMC host controller and exposes it on a simple 32-bit register bus. The command and data engines report events as single-cycle pulses. Each pulse sets a sticky flag that stays set until software writes a one to the matching bit of a separate clear register. Reading the status word does not clear anything.

An interrupt mask selects which sticky flags drive the single interrupt line. Two card pins enter through synchronizers: card-detect and write-protect. Their levels appear live in the status word. Every change of the synchronized card-detect level also raises a sticky card-change flag.

A self-clearing reset bit in the command word runs a fixed-length reset. The reset empties all sticky flags and the mask. Read data is registered, so it appears one clock after the read request.

Top module: `sd_stat_irq`

## Requirements
- R1: After reset, the command word, the status word (with both card pins low), the mask word and the clear word all read 0, and `irq` is 0.
- R2: A pulse on `evt_in[k]` (k = 0..9) sets status bit k. Bit 0 is response CRC fail, bit 1 data CRC fail, bit 2 response timeout, bit 3 data timeout, bit 4 response CRC good, bit 5 data CRC good, bit 6 command sent, bit 7 data end, bit 8 FIFO underrun and bit 9 FIFO overrun. The bit stays set after the pulse ends.
- R3: The register offsets are: command 0x00, status 0x28, clear 0x2C and mask 0x30. The mask reads back only its bits 10:0. The clear register reads as 0.
- R4: Writing 1 to bit k (k = 0..10) of the clear register resets sticky flag k. Zero bits leave their flags unchanged.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the flag ends up set.
- R6: `irq` is the OR over bits 10:0 of (sticky flag AND mask bit). With a mask of 0, `irq` stays 0.
- R7: Status bit 11 shows the card-detect pin and bit 12 shows the write-protect pin. Each passes through a two-flop synchronizer. Neither bit is sticky, and a write to the clear register does not affect them.
- R8: Status bit 10 (card change) is set on both rising and falling edges of the synchronized card-detect level. Changes on the write-protect pin do not set it.
- R9: Writing 1 to command bit 10 starts a reset. That bit then reads 1 for exactly 8 cycles and afterwards reads 0.
- R10: While the reset runs, all sticky flags and the mask are cleared. Event pulses and mask writes arriving during the reset are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| evt_in | input | 10 | Event pulses from the command and data engines |
| card_det_raw | input | 1 | Asynchronous card-detect pin |
| card_wp_raw | input | 1 | Asynchronous write-protect pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision of a hardware event and a software clear on the same bit in the same clock. A close second is an event or mask write landing inside the eight-cycle reset window. The bench reaches both by issuing back-to-back bus operations from one negedge-aligned driver. It raises `evt_in` in the same cycle as the clear write, and it places a pulse and a mask write in the first cycles after the reset command. Card-change edges in both directions come from holding each pin long enough to pass the synchronizer before reading.

// File: rtl/sdsi_pkg.sv
package sdsi_pkg;
    localparam int unsigned NFLAG   = 11;
    localparam int unsigned NEVT    = 10;
    localparam int unsigned AW      = 8;
    localparam int unsigned DW      = 32;
    localparam int unsigned RST_LEN = 8;

    localparam logic [AW-1:0] OFS_CMD  = 8'h00;
    localparam logic [AW-1:0] OFS_STAT = 8'h28;
    localparam logic [AW-1:0] OFS_CLR  = 8'h2C;
    localparam logic [AW-1:0] OFS_MASK = 8'h30;

    localparam int unsigned BIT_RST = 10;
    localparam int unsigned BIT_CHG = 10;
    localparam int unsigned BIT_DET = 11;
    localparam int unsigned BIT_WP  = 12;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic rd_en;
        logic cmd_we;
        logic clr_we;
        logic mask_we;
    } bus_dec_t;

    function automatic bus_dec_t decode(input logic sel, input logic wr,
                                        input logic [AW-1:0] addr);
        bus_dec_t d;
        d.rd_en   = sel && !wr;
        d.cmd_we  = sel && wr && (addr == OFS_CMD);
        d.clr_we  = sel && wr && (addr == OFS_CLR);
        d.mask_we = sel && wr && (addr == OFS_MASK);
        return d;
    endfunction
endpackage

// File: rtl/sdsi_pin_sync.sv
module sdsi_pin_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_s,
    output logic [W-1:0] pin_edge
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic st1, st2, st3;
        always_ff @(posedge clk) begin
            if (rst) begin
                st1 <= 1'b0;
                st2 <= 1'b0;
                st3 <= 1'b0;
            end else begin
                st1 <= pin_raw[i];
                st2 <= st1;
                st3 <= st2;
            end
        end
        assign pin_s[i]    = st2;
        assign pin_edge[i] = st2 ^ st3;
    end
endmodule

// File: rtl/sdsi_flags.sv
module sdsi_flags
    import sdsi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      busy,
    input  flag_vec_t set_vec,
    input  logic      clr_we,
    input  flag_vec_t clr_vec,
    output flag_vec_t flags
);
    flag_vec_t clr_eff;
    assign clr_eff = clr_we ? clr_vec : '0;

    always_ff @(posedge clk) begin
        if (rst || busy) flags <= '0;
        else             flags <= (flags & ~clr_eff) | set_vec;
    end
endmodule

// File: rtl/sdsi_ctrl.sv
module sdsi_ctrl
    import sdsi_pkg::*;
#(
    parameter int unsigned RST_CYC = RST_LEN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_we,
    input  logic      mask_we,
    input  logic      rst_req,
    input  flag_vec_t mask_wdata,
    output logic      busy,
    output flag_vec_t mask
);
    localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            mask <= '0;
        end else if (busy) begin
            mask <= '0;
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (cmd_we && rst_req) begin
            busy <= 1'b1;
            cnt  <= CW'(RST_CYC - 1);
        end else if (mask_we) begin
            mask <= mask_wdata;
        end
    end
endmodule

// File: rtl/sd_stat_irq.sv
module sd_stat_irq
    import sdsi_pkg::*;
#(
    parameter int unsigned RST_CYC = RST_LEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NEVT-1:0]      evt_in,
    input  logic                 card_det_raw,
    input  logic                 card_wp_raw,
    output logic                 irq
);
    bus_dec_t  dec;
    logic      busy;
    logic      clr_we;
    flag_vec_t clr_vec;
    flag_vec_t flags;
    flag_vec_t mask;
    flag_vec_t set_vec;
    logic [1:0] pin_s, pin_edge;

    assign dec     = decode(bus_sel, bus_wr, bus_addr);
    assign clr_we  = dec.clr_we;
    assign clr_vec = bus_wdata[NFLAG-1:0];

    sdsi_pin_sync #(.W(2)) u_sync (
        .clk(clk), .rst(rst),
        .pin_raw({card_wp_raw, card_det_raw}),
        .pin_s(pin_s), .pin_edge(pin_edge)
    );

    assign set_vec = {pin_edge[0], evt_in};

    sdsi_flags u_flags (
        .clk(clk), .rst(rst), .busy(busy),
        .set_vec(set_vec), .clr_we(clr_we), .clr_vec(clr_vec),
        .flags(flags)
    );

    sdsi_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_we(dec.cmd_we), .mask_we(dec.mask_we),
        .rst_req(bus_wdata[BIT_RST]), .mask_wdata(clr_vec),
        .busy(busy), .mask(mask)
    );

    assign irq = |(flags & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (dec.rd_en) begin
            bus_rdata <= '0;
            unique case (bus_addr)
                OFS_CMD:  bus_rdata[BIT_RST] <= busy;
                OFS_STAT: begin
                    bus_rdata[NFLAG-1:0] <= flags;
                    bus_rdata[BIT_DET]   <= pin_s[0];
                    bus_rdata[BIT_WP]    <= pin_s[1];
                end
                OFS_MASK: bus_rdata[NFLAG-1:0] <= mask;
                default:  bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sdsi_chk.sv
module sdsi_chk
    import sdsi_pkg::*;
#(
    parameter int unsigned RST_CYC = RST_LEN
) (
    input logic      clk,
    input logic      rst,
    input logic      busy,
    input flag_vec_t flags,
    input flag_vec_t mask,
    input flag_vec_t set_vec,
    input logic      clr_we,
    input flag_vec_t clr_vec,
    input logic      irq
);
    int unsigned busy_run;
    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R2 R5: a set outside reset always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec && !busy) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    // R4: a cleared bit without a concurrent set reads 0 next cycle
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !busy) |=> ((flags & $past(clr_vec & ~set_vec)) == '0));

    // R6: zero mask means no interrupt
    a_r6_mask_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

    // R10: reset window empties flags and mask
    a_r10_busy_clears: assert property (@(posedge clk) disable iff (rst)
        busy |=> (flags == '0 && mask == '0));

    // R9: reset window lasts exactly RST_CYC cycles
    a_r9_busy_len: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == RST_CYC));
endmodule

bind sd_stat_irq sdsi_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .flags(flags), .mask(mask),
    .set_vec(set_vec), .clr_we(clr_we), .clr_vec(clr_vec), .irq(irq)
);

// File: tb/sd_stat_irq_tb.sv
module sd_stat_irq_tb;
    import sdsi_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [9:0]    evt_in = '0;
    logic          card_det_raw = 1'b0;
    logic          card_wp_raw = 1'b0;
    logic          irq;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #5 clk = ~clk;

    sd_stat_irq u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .card_det_raw(card_det_raw),
        .card_wp_raw(card_wp_raw), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (bus_sel && !bus_wr) begin
                if (sbq.size() == 0) begin
                    check("scoreboard underflow", 32'd1, 32'd0);
                end else begin
                    sb_item_t it;
                    it = sbq.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_in = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_in = '0;
        @(negedge clk);
    endtask

    task automatic wr_evt(logic [7:0] a, logic [31:0] d, logic [9:0] e);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_in = e;
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; evt_in = '0;
        @(negedge clk);
    endtask

    task automatic pulse(logic [9:0] e);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #500us;
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] acc;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        rd(OFS_CMD,  32'h0, "R1 command word");
        rd(OFS_STAT, 32'h0, "R1 status word");
        rd(OFS_MASK, 32'h0, "R1 mask word");
        rd(OFS_CLR,  32'h0, "R3 clear reads zero");

        // R2 each event bit sets its own sticky flag
        acc = 32'h0;
        for (int k = 0; k < 10; k++) begin
            pulse(10'(1 << k));
            acc |= 32'(1 << k);
            rd(OFS_STAT, acc, "R2 event sets flag");
        end
        idle(3);
        rd(OFS_STAT, 32'h3FF, "R2 flags stay set");

        // R4 partial and full clear
        wr(OFS_CLR, 32'h0F0);
        rd(OFS_STAT, 32'h30F, "R4 partial clear");
        wr(OFS_CLR, 32'h0);
        rd(OFS_STAT, 32'h30F, "R4 zero write keeps flags");
        wr(OFS_CLR, 32'hFFFF_FFFF);
        rd(OFS_STAT, 32'h0, "R4 full clear");

        // R5 set beats clear in the same cycle
        pulse(10'h0C0);
        wr_evt(OFS_CLR, 32'h0C0, 10'h040);
        rd(OFS_STAT, 32'h040, "R5 set wins over clear");

        // R6 interrupt masking
        idle(1);
        check("R6 mask zero no irq", {31'b0, irq}, 32'd0);
        wr(OFS_MASK, 32'h080);
        check("R6 unrelated mask no irq", {31'b0, irq}, 32'd0);
        rd(OFS_MASK, 32'h080, "R3 mask readback");
        wr(OFS_MASK, 32'hFFFF_F040);
        check("R6 masked flag raises irq", {31'b0, irq}, 32'd1);
        rd(OFS_MASK, 32'h040, "R3 mask upper bits dropped");
        wr(OFS_CLR, 32'h040);
        check("R6 irq drops after clear", {31'b0, irq}, 32'd0);

        // R7 R8 card pins
        idle(1);
        card_det_raw = 1'b1;
        idle(5);
        rd(OFS_STAT, 32'h0C00, "R8 rise sets change, R7 detect level");
        wr(OFS_CLR, 32'h1C00);
        rd(OFS_STAT, 32'h0800, "R7 detect level not sticky-cleared");
        card_det_raw = 1'b0;
        idle(5);
        rd(OFS_STAT, 32'h0400, "R8 fall sets change");
        wr(OFS_CLR, 32'h400);
        card_wp_raw = 1'b1;
        idle(5);
        rd(OFS_STAT, 32'h1000, "R7 write-protect level, R8 no change");
        card_wp_raw = 1'b0;
        idle(5);
        rd(OFS_STAT, 32'h0000, "R7 write-protect not sticky");

        // R9 R10 self-clearing reset
        pulse(10'h005);
        wr(OFS_MASK, 32'h7FF);
        check("R6 irq before reset", {31'b0, irq}, 32'd1);
        wr(OFS_CMD, 32'h400);
        for (int k = 0; k < 8; k++) rd(OFS_CMD, 32'h400, "R9 busy bit held");
        rd(OFS_CMD, 32'h0, "R9 busy bit self-clears");
        rd(OFS_STAT, 32'h0, "R10 flags cleared by reset");
        rd(OFS_MASK, 32'h0, "R10 mask cleared by reset");
        check("R10 irq low after reset", {31'b0, irq}, 32'd0);

        wr(OFS_CMD, 32'h400);
        pulse(10'h008);
        wr(OFS_MASK, 32'h7FF);
        idle(10);
        rd(OFS_STAT, 32'h0, "R10 event during reset lost");
        rd(OFS_MASK, 32'h0, "R10 mask write during reset lost");
        pulse(10'h008);
        rd(OFS_STAT, 32'h008, "R2 events work after reset");

        idle(3);
        check("scoreboard drained", 32'(sbq.size()), 32'd0);
        finish_run();
    end
endmodule